// File: doc/BRIEF.md
# Z-Order Prediction Unit Cost Accumulator

This block sits after a 4×4 SATD stage in an intra encoder. It takes one 4×4 block at a time, in Z-order scan across a 64×64 coding tree unit. Each beat carries a parameterised number of candidate intra modes, one SATD cost per mode. From these it forms the per-mode cost of every prediction unit from 4×4 up to 32×32. That covers square units and rectangles with aspect ratios 1:2, 2:1, 1:4 and 4:1. For each unit it reports the cheapest mode and that cost. A rectangle's cost is an approximation: the sum of the costs of the square pieces inside it, which equals the sum of its 4×4 costs.

All fourteen shapes come from one parameterised lane circuit. A lane keeps one running per-mode sum for each unit of its shape that is still open. It emits a unit in the cycle after the beat that carries that unit's bottom-right 4×4 block. In Z-order, that block is always the last member of the unit to arrive. Mode indices use a 6-bit field, so any of the 61 intra modes (56 directional, 5 non-directional) can be named.

Top module: `zpu_cost_accum`

## Requirements
- R1: Beat k after reset (counted modulo 256, idle cycles not counted) is the 4×4 block whose column index is bits 0,2,4,6 of k and whose row index is bits 1,3,5,7 of k, with bit 0 of k the lowest column bit.
- R2: Every accepted beat produces a 4×4 result on lane 0 one cycle later: the minimum of that beat's costs and the mode that has it.
- R3: Accumulators are COST_W+6 bits wide, so a 32×32 unit whose 64 costs are all at the maximum input value sums exactly.
- R4: The 8×8, 16×16 and 32×32 results hold, per mode, the sum of the 4×4 costs inside the unit. Each is emitted one cycle after the beat of its bottom-right 4×4 block.
- R5: The 1:2 and 2:1 rectangles (4×8, 8×4, 8×16, 16×8, 16×32, 32×16) are emitted in the same way, with the per-mode sum over their area.
- R6: The 1:4 and 4:1 rectangles (4×16, 16×4, 8×32, 32×8) keep their partial sums across blocks that are not adjacent in Z-order, and are emitted only after their last block.
- R7: When several modes tie at the minimum, the lowest mode index is reported.
- R8: Lane i reports a fixed shape. The lanes in order have (width code, height code) (0,0) (0,1) (0,2) (1,0) (1,1) (1,2) (1,3) (2,0) (2,1) (2,2) (2,3) (3,1) (3,2) (3,3), where side = 4 << code. pu_x and pu_y give the pixel position of the unit's top-left corner.
- R9: While reset is asserted, and in the first cycle after it, all pu_valid bits are 0.
- R10: A cycle with in_valid low produces no pu_valid and does not advance the scan position.
- R11: After beat 255 the position returns to 0, and the next unit sums start afresh with no carry-over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat strobe for one 4×4 block |
| in_cost | input | N_MODES×COST_W | SATD cost per candidate mode, mode m at slice m |
| pu_valid | output | N_SHAPE | Per-lane result strobe |
| pu_cost | output | N_SHAPE×ACC_W | Minimum summed cost per lane |
| pu_mode | output | N_SHAPE×MODE_W | Mode index of that minimum |
| pu_x | output | N_SHAPE×(GRID_LOG+2) | Top-left x in pixels |
| pu_y | output | N_SHAPE×(GRID_LOG+2) | Top-left y in pixels |
| pu_wcode | output | N_SHAPE×2 | Width code, width = 4 << code |
| pu_hcode | output | N_SHAPE×2 | Height code, height = 4 << code |

## Verification
A corrupted running sum in a lane stays invisible until that unit's last block arrives. The wrong cost or mode then shows at the unit's emission, which for a 32×32 unit can be up to 63 beats later. A scan position that is off by one breaks the placement on the very next emission of every lane: pu_x and pu_y are wrong, or the strobe lands on the wrong beat. So the bench checks every lane on every beat, not only the final minimum. Slot aliasing in the 1:4 lanes only shows when the interleaved units hold different data, so the cost patterns vary with position.

// File: rtl/zpu_pkg.sv
package zpu_pkg;
  localparam int MAX_CODE = 3;  // largest side code: 4 << 3 = 32
  localparam int N_SHAPE  = 14;

  // Enumerate (width code, height code) with aspect ratio at most 4:1
  function automatic int shape_code(input int idx, input bit want_h);
    int n = 0;
    int r = 0;
    for (int w = 0; w <= MAX_CODE; w++)
      for (int h = 0; h <= MAX_CODE; h++)
        if ((w - h) <= 2 && (h - w) <= 2) begin
          if (n == idx) r = want_h ? h : w;
          n++;
        end
    return r;
  endfunction
endpackage

// File: rtl/zpu_zpos.sv
module zpu_zpos #(
  parameter int GRID_LOG = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  output logic [GRID_LOG-1:0] gx,
  output logic [GRID_LOG-1:0] gy
);
  localparam int CNT_W = 2 * GRID_LOG;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  for (genvar b = 0; b < GRID_LOG; b++) begin : g_bits
    assign gx[b] = cnt[2*b];
    assign gy[b] = cnt[2*b+1];
  end

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && cnt == '1) |=> (cnt == '0)); // R11
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R10
endmodule

// File: rtl/zpu_argmin.sv
module zpu_argmin #(
  parameter int N      = 8,
  parameter int VAL_W  = 18,
  parameter int MODE_W = 6
) (
  input  logic [N-1:0][VAL_W-1:0] vals,
  output logic [VAL_W-1:0]        best,
  output logic [MODE_W-1:0]       best_idx
);
  // Strict compare from the lowest index keeps the lower mode on a tie
  always_comb begin
    best     = vals[0];
    best_idx = '0;
    for (int m = 1; m < N; m++) begin
      if (vals[m] < best) begin
        best     = vals[m];
        best_idx = MODE_W'(m);
      end
    end
  end
endmodule

// File: rtl/zpu_lane.sv
module zpu_lane #(
  parameter int N_MODES  = 8,
  parameter int COST_W   = 12,
  parameter int ACC_W    = 18,
  parameter int MODE_W   = 6,
  parameter int GRID_LOG = 4,
  parameter int WC       = 0,
  parameter int HC       = 0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic [N_MODES-1:0][COST_W-1:0]  costs,
  input  logic [GRID_LOG-1:0]             gx,
  input  logic [GRID_LOG-1:0]             gy,
  output logic                            out_valid,
  output logic [ACC_W-1:0]                out_cost,
  output logic [MODE_W-1:0]               out_mode,
  output logic [GRID_LOG+1:0]             out_x,
  output logic [GRID_LOG+1:0]             out_y
);
  localparam int W      = 1 << WC;   // width in 4x4 blocks
  localparam int H      = 1 << HC;
  localparam int NSLOT  = (W > H) ? W / H : H / W;
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [GRID_LOG-1:0] WMASK = GRID_LOG'(W - 1);
  localparam logic [GRID_LOG-1:0] HMASK = GRID_LOG'(H - 1);

  logic [ACC_W-1:0] acc [NSLOT][N_MODES];
  logic [N_MODES-1:0][ACC_W-1:0] sum;
  logic [SLOT_W-1:0] slot;
  logic first, last;
  logic [ACC_W-1:0]  min_cost;
  logic [MODE_W-1:0] min_mode;

  // Tall units sit side by side across a row band, wide units stack down a column band
  assign slot  = (W < H) ? SLOT_W'((gx >> WC) & (NSLOT - 1))
                         : SLOT_W'((gy >> HC) & (NSLOT - 1));
  assign first = ((gx & WMASK) == '0) && ((gy & HMASK) == '0);
  assign last  = ((gx & WMASK) == WMASK) && ((gy & HMASK) == HMASK);

  always_comb begin
    for (int m = 0; m < N_MODES; m++)
      sum[m] = (first ? '0 : acc[slot][m]) + ACC_W'(costs[m]);
  end

  zpu_argmin #(.N(N_MODES), .VAL_W(ACC_W), .MODE_W(MODE_W)) u_min (
    .vals(sum), .best(min_cost), .best_idx(min_mode)
  );

  // Running sums: plain storage, no reset, one slot written per beat
  always_ff @(posedge clk) begin
    if (in_valid && !last)
      for (int m = 0; m < N_MODES; m++) acc[slot][m] <= sum[m];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid && last;
    end
    if (in_valid && last) begin
      out_cost <= min_cost;
      out_mode <= min_mode;
      out_x    <= {gx & ~WMASK, 2'b00};
      out_y    <= {gy & ~HMASK, 2'b00};
    end
  end

  for (genvar m = 0; m < N_MODES; m++) begin : g_ovf
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (sum[m] >= ACC_W'(costs[m]))); // R3
  end
  AST_EMIT_NEEDS_BEAT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R10
  AST_MODE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mode < MODE_W'(N_MODES))); // R7
endmodule

// File: rtl/zpu_cost_accum.sv
module zpu_cost_accum #(
  parameter int N_MODES  = 8,
  parameter int COST_W   = 12,
  parameter int MODE_W   = 6,
  parameter int GRID_LOG = 4,
  localparam int ACC_W   = COST_W + 2 * zpu_pkg::MAX_CODE,
  localparam int PIX_W   = GRID_LOG + 2,
  localparam int N_SHAPE = zpu_pkg::N_SHAPE
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  input  logic [N_MODES-1:0][COST_W-1:0]   in_cost,
  output logic [N_SHAPE-1:0]               pu_valid,
  output logic [N_SHAPE-1:0][ACC_W-1:0]    pu_cost,
  output logic [N_SHAPE-1:0][MODE_W-1:0]   pu_mode,
  output logic [N_SHAPE-1:0][PIX_W-1:0]    pu_x,
  output logic [N_SHAPE-1:0][PIX_W-1:0]    pu_y,
  output logic [N_SHAPE-1:0][1:0]          pu_wcode,
  output logic [N_SHAPE-1:0][1:0]          pu_hcode
);
  logic [GRID_LOG-1:0] gx, gy;

  zpu_zpos #(.GRID_LOG(GRID_LOG)) u_pos (
    .clk(clk), .rst(rst), .step(in_valid), .gx(gx), .gy(gy)
  );

  for (genvar i = 0; i < N_SHAPE; i++) begin : g_lane
    localparam int WC = zpu_pkg::shape_code(i, 1'b0);
    localparam int HC = zpu_pkg::shape_code(i, 1'b1);
    assign pu_wcode[i] = 2'(WC);
    assign pu_hcode[i] = 2'(HC);
    zpu_lane #(
      .N_MODES(N_MODES), .COST_W(COST_W), .ACC_W(ACC_W), .MODE_W(MODE_W),
      .GRID_LOG(GRID_LOG), .WC(WC), .HC(HC)
    ) u_lane (
      .clk(clk), .rst(rst), .in_valid(in_valid), .costs(in_cost),
      .gx(gx), .gy(gy),
      .out_valid(pu_valid[i]), .out_cost(pu_cost[i]), .out_mode(pu_mode[i]),
      .out_x(pu_x[i]), .out_y(pu_y[i])
    );
  end

  AST_SQ4_EVERY_BEAT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> pu_valid[0]); // R2
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (pu_valid == '0)); // R10
endmodule

// File: tb/zpu_cost_accum_test.sv
module zpu_cost_accum_test;
  localparam int NM = 8;
  localparam int CW = 12;
  localparam int AW = CW + 6;
  localparam int NS = 14;
  localparam int LW [NS] = '{0,0,0,1,1,1,1,2,2,2,2,3,3,3};
  localparam int LH [NS] = '{0,1,2,0,1,2,3,0,1,2,3,1,2,3};

  logic clk = 0, rst = 1, in_valid = 0;
  logic [NM-1:0][CW-1:0] in_cost = '0;
  logic [NS-1:0] pu_valid;
  logic [NS-1:0][AW-1:0] pu_cost;
  logic [NS-1:0][5:0] pu_mode, pu_x, pu_y;
  logic [NS-1:0][1:0] pu_wcode, pu_hcode;

  int checks = 0, errors = 0;
  int mem [256][NM];
  int seed = 12345;

  always #10 clk = ~clk;

  zpu_cost_accum uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cost(in_cost),
    .pu_valid(pu_valid), .pu_cost(pu_cost), .pu_mode(pu_mode),
    .pu_x(pu_x), .pu_y(pu_y), .pu_wcode(pu_wcode), .pu_hcode(pu_hcode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int zidx(input int x, input int y);
    int r = 0;
    for (int b = 0; b < 4; b++) r |= (((x >> b) & 1) << (2*b)) | (((y >> b) & 1) << (2*b+1));
    return r;
  endfunction

  function automatic string lane_req(input int l);
    int d = LW[l] - LH[l];
    if (l == 0) return "R2";
    if (d == 0) return "R4";
    if (d == 1 || d == -1) return "R5";
    return "R6";
  endfunction

  // Compare every lane against sums computed from the stored costs
  task automatic check_beat(input int p, input string tag);
    int x = 0, y = 0;
    for (int b = 0; b < 4; b++) begin
      x |= ((p >> (2*b)) & 1) << b;
      y |= ((p >> (2*b+1)) & 1) << b;
    end
    for (int l = 0; l < NS; l++) begin
      int w = 1 << LW[l];
      int h = 1 << LH[l];
      string rq = {lane_req(l), " ", tag};
      bit last = ((x % w) == w-1) && ((y % h) == h-1);
      chk(pu_valid[l] == last, rq, $sformatf("valid lane %0d pos %0d", l, p), pu_valid[l], last);
      if (last) begin
        int x0 = x - (w-1), y0 = y - (h-1);
        int best = -1, bidx = 0;
        for (int m = 0; m < NM; m++) begin
          int s = 0;
          for (int dy = 0; dy < h; dy++)
            for (int dx = 0; dx < w; dx++) s += mem[zidx(x0+dx, y0+dy)][m];
          if (best < 0 || s < best) begin best = s; bidx = m; end
        end
        chk(pu_cost[l] == AW'(best), rq, $sformatf("cost lane %0d pos %0d", l, p), pu_cost[l], best);
        chk(pu_mode[l] == 6'(bidx), {rq, " R7"}, $sformatf("mode lane %0d", l), pu_mode[l], bidx);
        chk(pu_x[l] == 6'(x0*4) && pu_y[l] == 6'(y0*4), {"R1 R8 ", tag},
            $sformatf("xy lane %0d", l), {pu_x[l], pu_y[l]}, {6'(x0*4), 6'(y0*4)});
        chk(pu_wcode[l] == 2'(LW[l]) && pu_hcode[l] == 2'(LH[l]), "R8",
            $sformatf("shape lane %0d", l), {pu_wcode[l], pu_hcode[l]}, {2'(LW[l]), 2'(LH[l])});
      end
    end
  endtask

  task automatic idle_cycle(input string tag);
    @(posedge clk); @(negedge clk);
    chk(pu_valid == '0, {"R10 ", tag}, "valid during idle", pu_valid, 0);
  endtask

  // kind 0: pseudo-random, 1: ties at modes 3 and 6, 2: near-maximum costs
  task automatic run_ctu(input int kind, input int gap_every, input string tag);
    for (int p = 0; p < 256; p++)
      for (int m = 0; m < NM; m++) begin
        seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
        if (kind == 0)      mem[p][m] = (seed & 32'h7fffffff) % 4096;
        else if (kind == 1) mem[p][m] = (m == 3 || m == 6) ? 50 : 200;
        else                mem[p][m] = (m == 7) ? 4094 : 4095;
      end
    for (int p = 0; p < 256; p++) begin
      for (int m = 0; m < NM; m++) in_cost[m] = CW'(mem[p][m]);
      in_valid = 1;
      @(posedge clk); @(negedge clk);
      in_valid = 0;
      in_cost = '1;
      check_beat(p, tag);
      if (gap_every > 0 && (p % gap_every) == gap_every - 1) begin
        idle_cycle(tag);
        idle_cycle(tag);
      end
    end
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    chk(pu_valid == '0, "R9", "valid in reset", pu_valid, 0);
    rst = 0;
    @(negedge clk);
    chk(pu_valid == '0, "R9", "valid after reset", pu_valid, 0);
  endtask

  task automatic t_random;   run_ctu(0, 0, "R4 R5 R6"); endtask
  task automatic t_wrap;     run_ctu(0, 0, "R11");      endtask
  task automatic t_ties;     run_ctu(1, 0, "R7");       endtask
  task automatic t_max;      run_ctu(2, 0, "R3");       endtask
  task automatic t_gaps;     run_ctu(0, 7, "R10");      endtask

  initial begin
    t_reset();
    t_random();
    t_wrap();
    t_ties();
    t_max();
    t_gaps();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule